// File: doc/BRIEF.md
# LRU Stack-Distance Profiler

This block observes a stream of cache lookups and, for every set, keeps a recency-ordered list of the tags seen there. Each lookup is classified by how deep in that list its tag sits. A hit at depth p (0 is the most recent entry) bumps the counter in that set's column p. A lookup whose tag is absent bumps that set's miss counter. This covers tags that were never seen and tags that were pushed out by more than the configured number of ways.

From the count matrix the block derives a loss vector. Entry i of the vector is the number of misses the cache would suffer if i ways of every set were unusable. It equals the total of the miss column plus every hit recorded in the i deepest positions. A single pass over the trace therefore yields the miss count for every reduced associativity from full down to zero ways. Software or a debug engine reads the matrix and the vector back one word per cycle through a registered select/data port.

The lookup address is split with the set index in the low bits and the tag in the bits above it. A synchronous clear wipes all counters and all recency lists without a reset.

Top module: `stackprof`

## Requirements
- R1: After reset or after `clear`, every matrix counter and every vector entry reads 0. Every recency list is empty, so the first lookup of any tag afterwards counts as a miss.
- R2: A lookup whose tag sits at depth p (0 = most recent, WAYS-1 = least recent) of its set's list adds one to matrix column p of that set only.
- R3: A lookup whose tag is not in its set's list adds one to that set's miss column, which is column index WAYS.
- R4: On a hit at depth p, the tag moves to depth 0 and the entries from depth 0 to p-1 each move one step deeper. On a miss, the new tag enters at depth 0, every entry moves one step deeper, and the entry at depth WAYS-1 is dropped.
- R5: Matrix counters stop at 2^CNT_W-1 and never wrap.
- R6: Vector entry i equals the sum over all sets of the miss column plus columns WAYS-i through WAYS-1. Entry 0 is the full-associativity miss total, and entry WAYS is the number of counted lookups.
- R7: A read request on `rdEn` returns its word on `rdData` with `rdValid` high one cycle later. `rdVec`=0 selects matrix cell (`rdSet`,`rdCol`) and `rdVec`=1 selects vector entry `rdCol`. Any `rdCol` above WAYS returns 0.
- R8: A read issued in the same cycle as a lookup returns the value from before that lookup.
- R9: When `clear` and `accValid` are high in the same cycle, the lookup is dropped and has no effect on any counter or list.
- R10: Lookups to one set leave the lists and counters of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous wipe of counters and lists |
| accValid | input | 1 | Lookup present this cycle |
| accAddr | input | TAG_W+SET_W | Lookup address: tag in the upper bits, set in the low SET_W bits |
| rdEn | input | 1 | Read request |
| rdVec | input | 1 | 0 selects a matrix cell, 1 selects a vector entry |
| rdSet | input | SET_W | Set selected for a matrix read |
| rdCol | input | COL_W | Column or vector index |
| rdData | output | SUM_W | Read result, registered |
| rdValid | output | 1 | rdData holds the result of the previous cycle's request |

## Verification
Two pairs of functions can fall in the same cycle: a readout with a lookup, and a clear with a lookup. The bench provokes the first by issuing a miss-column read in the very cycle a fresh tag misses in that set. It expects the old count first and the incremented count on a second read. It provokes the second by raising clear together with a lookup. It then expects the whole matrix and vector to read zero, and expects a following lookup of a tag that was resident before the clear to land in the miss column.

// File: rtl/stackprof_pkg.sv
package stackprof_pkg;
  typedef struct packed {
    logic clrAll;
    logic doUpd;
    logic doRead;
  } strobe_t;
endpackage

// File: rtl/stackprof_ctrl.sv
module stackprof_ctrl
  import stackprof_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    clear,
  input  logic    accValid,
  input  logic    rdEn,
  output strobe_t stb,
  output logic    rdValid
);
  // clear has priority over a lookup in the same cycle
  always_comb begin
    stb.clrAll = clear;
    stb.doUpd  = accValid && !clear;
    stb.doRead = rdEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= rdEn;
  end
endmodule

// File: rtl/stackprof_stack.sv
module stackprof_stack
  import stackprof_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  parameter int SET_W = 2,
  parameter int COL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [SET_W-1:0] setIdx,
  input  logic [TAG_W-1:0] tag,
  output logic [COL_W-1:0] colIdx
);
  logic [TAG_W-1:0] stk [SETS][WAYS];
  logic [WAYS-1:0]  vld [SETS];

  logic [TAG_W-1:0] curTag [WAYS];
  logic [WAYS-1:0]  curVld;
  logic [WAYS-1:0]  match;
  logic             hit;
  logic [COL_W-1:0] hitPos;
  logic [COL_W-1:0] limit;
  logic [TAG_W-1:0] nxtTag [WAYS];
  logic [WAYS-1:0]  nxtVld;

  // select the addressed set's list
  always_comb begin
    curVld = '0;
    for (int p = 0; p < WAYS; p++) curTag[p] = '0;
    for (int s = 0; s < SETS; s++) begin
      if (setIdx == SET_W'(s)) begin
        curVld = vld[s];
        for (int p = 0; p < WAYS; p++) curTag[p] = stk[s][p];
      end
    end
  end

  for (genvar p = 0; p < WAYS; p++) begin : gMatch
    assign match[p] = curVld[p] && (curTag[p] == tag);
  end

  // shallowest matching depth
  always_comb begin
    hit    = 1'b0;
    hitPos = '0;
    for (int p = WAYS - 1; p >= 0; p--) begin
      if (match[p]) begin
        hit    = 1'b1;
        hitPos = COL_W'(p);
      end
    end
  end

  assign colIdx = hit ? hitPos : COL_W'(WAYS);
  assign limit  = hit ? hitPos : COL_W'(WAYS - 1);

  // new list: tag to depth 0, entries down to limit shift one deeper
  always_comb begin
    nxtTag[0] = tag;
    nxtVld[0] = 1'b1;
    for (int p = 1; p < WAYS; p++) begin
      if (COL_W'(p) <= limit) begin
        nxtTag[p] = curTag[p-1];
        nxtVld[p] = curVld[p-1];
      end else begin
        nxtTag[p] = curTag[p];
        nxtVld[p] = curVld[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s] <= '0;
        for (int p = 0; p < WAYS; p++) stk[s][p] <= '0;
      end
    end else if (stb.clrAll) begin
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
    end else if (stb.doUpd) begin
      for (int s = 0; s < SETS; s++) begin
        if (setIdx == SET_W'(s)) begin
          vld[s] <= nxtVld;
          for (int p = 0; p < WAYS; p++) stk[s][p] <= nxtTag[p];
        end
      end
    end
  end
endmodule

// File: rtl/stackprof_cnt.sv
module stackprof_cnt
  import stackprof_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int CNT_W = 16,
  parameter int SET_W = 2,
  parameter int COL_W = 3,
  parameter int SUM_W = 21
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [SET_W-1:0] setIdx,
  input  logic [COL_W-1:0] colIdx,
  input  logic             rdVec,
  input  logic [SET_W-1:0] rdSet,
  input  logic [COL_W-1:0] rdCol,
  output logic [SUM_W-1:0] rdData
);
  localparam int NCOL = WAYS + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt    [SETS][NCOL];
  logic [SUM_W-1:0] colSum [NCOL];
  logic [SUM_W-1:0] vec    [NCOL];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++)
        for (int c = 0; c < NCOL; c++) cnt[s][c] <= '0;
    end else if (stb.clrAll) begin
      for (int s = 0; s < SETS; s++)
        for (int c = 0; c < NCOL; c++) cnt[s][c] <= '0;
    end else if (stb.doUpd) begin
      for (int s = 0; s < SETS; s++)
        for (int c = 0; c < NCOL; c++)
          if (setIdx == SET_W'(s) && colIdx == COL_W'(c) && cnt[s][c] != CNT_MAX)
            cnt[s][c] <= cnt[s][c] + 1'b1;
    end
  end

  // column totals across sets
  for (genvar c = 0; c < NCOL; c++) begin : gCol
    always_comb begin
      colSum[c] = '0;
      for (int s = 0; s < SETS; s++) colSum[c] = colSum[c] + SUM_W'(cnt[s][c]);
    end
  end

  // accumulate from the miss column toward the most recent position
  assign vec[0] = colSum[WAYS];
  for (genvar i = 1; i < NCOL; i++) begin : gVec
    assign vec[i] = vec[i-1] + colSum[WAYS-i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (stb.doRead) begin
      rdData <= '0;
      for (int c = 0; c < NCOL; c++) begin
        if (rdCol == COL_W'(c)) begin
          if (rdVec) rdData <= vec[c];
          else begin
            for (int s = 0; s < SETS; s++)
              if (rdSet == SET_W'(s)) rdData <= SUM_W'(cnt[s][c]);
          end
        end
      end
    end
  end
endmodule

// File: rtl/stackprof.sv
module stackprof
  import stackprof_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  parameter int CNT_W = 16,
  localparam int SET_W  = $clog2(SETS),
  localparam int COL_W  = $clog2(WAYS + 1),
  localparam int ADDR_W = TAG_W + SET_W,
  localparam int SUM_W  = CNT_W + $clog2(SETS * (WAYS + 1))
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              rdEn,
  input  logic              rdVec,
  input  logic [SET_W-1:0]  rdSet,
  input  logic [COL_W-1:0]  rdCol,
  output logic [SUM_W-1:0]  rdData,
  output logic              rdValid
);
  strobe_t          stb;
  logic [COL_W-1:0] colIdx;
  logic [SET_W-1:0] setIdx;
  logic [TAG_W-1:0] tag;

  assign setIdx = accAddr[SET_W-1:0];
  assign tag    = accAddr[ADDR_W-1:SET_W];

  stackprof_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .clear(clear), .accValid(accValid),
    .rdEn(rdEn), .stb(stb), .rdValid(rdValid)
  );

  stackprof_stack #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .SET_W(SET_W), .COL_W(COL_W)
  ) uStack (
    .clk(clk), .rstN(rstN), .stb(stb), .setIdx(setIdx), .tag(tag), .colIdx(colIdx)
  );

  stackprof_cnt #(
    .SETS(SETS), .WAYS(WAYS), .CNT_W(CNT_W), .SET_W(SET_W), .COL_W(COL_W), .SUM_W(SUM_W)
  ) uCnt (
    .clk(clk), .rstN(rstN), .stb(stb), .setIdx(setIdx), .colIdx(colIdx),
    .rdVec(rdVec), .rdSet(rdSet), .rdCol(rdCol), .rdData(rdData)
  );
endmodule

// File: rtl/stackprof_chk.sv
module stackprof_chk #(
  parameter int WAYS  = 4,
  parameter int SET_W = 2,
  parameter int COL_W = 3,
  parameter int SUM_W = 21
) (
  input logic             clk,
  input logic             rstN,
  input logic             clear,
  input logic             accValid,
  input logic             rdEn,
  input logic             rdVec,
  input logic [SET_W-1:0] rdSet,
  input logic [COL_W-1:0] rdCol,
  input logic [SUM_W-1:0] rdData,
  input logic             rdValid
);
  assert_rd_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  assert_rd_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);

  assert_unused_col_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdCol > COL_W'(WAYS)) |=> (rdData == '0));

  assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(clear) && rdEn) |=> (rdData == '0));

  assert_no_lookup_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && $past(rdEn) && $stable(rdVec) && $stable(rdSet) && $stable(rdCol)
     && !$past(accValid) && !$past(clear)) |=> $stable(rdData));

  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && $past(rdEn) && $stable(rdVec) && $stable(rdSet) && $stable(rdCol)
     && !$past(clear)) |=> (rdData >= $past(rdData)));
endmodule

bind stackprof stackprof_chk #(
  .WAYS(WAYS), .SET_W(SET_W), .COL_W(COL_W), .SUM_W(SUM_W)
) uChk (
  .clk(clk), .rstN(rstN), .clear(clear), .accValid(accValid), .rdEn(rdEn),
  .rdVec(rdVec), .rdSet(rdSet), .rdCol(rdCol), .rdData(rdData), .rdValid(rdValid)
);

// File: tb/stackprof_test.sv
module stackprof_test;
  localparam int SETS   = 4;
  localparam int WAYS   = 4;
  localparam int TAG_W  = 4;
  localparam int CNT_W  = 6;
  localparam int SET_W  = $clog2(SETS);
  localparam int COL_W  = $clog2(WAYS + 1);
  localparam int ADDR_W = TAG_W + SET_W;
  localparam int SUM_W  = CNT_W + $clog2(SETS * (WAYS + 1));
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clear = 1'b0;
  logic accValid = 1'b0;
  logic [ADDR_W-1:0] accAddr = '0;
  logic rdEn = 1'b0;
  logic rdVec = 1'b0;
  logic [SET_W-1:0] rdSet = '0;
  logic [COL_W-1:0] rdCol = '0;
  logic [SUM_W-1:0] rdData;
  logic rdValid;

  int nTests = 0;
  int nFail  = 0;
  int cyc    = 0;

  int mStk [SETS][WAYS];
  bit mVld [SETS][WAYS];
  int mCnt [SETS][WAYS+1];

  always #4 clk = ~clk;

  stackprof #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .clear(clear), .accValid(accValid), .accAddr(accAddr),
    .rdEn(rdEn), .rdVec(rdVec), .rdSet(rdSet), .rdCol(rdCol),
    .rdData(rdData), .rdValid(rdValid)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nFail++;
      $display("FAIL watchdog (R1 R7): actual cycles=%0d expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void modelClear();
    for (int s = 0; s < SETS; s++)
      for (int p = 0; p < WAYS; p++) begin mVld[s][p] = 0; mStk[s][p] = 0; end
    for (int s = 0; s < SETS; s++)
      for (int c = 0; c <= WAYS; c++) mCnt[s][c] = 0;
  endfunction

  function automatic void modelAccess(input int s, input int t);
    int d = WAYS;
    for (int p = WAYS - 1; p >= 0; p--) if (mVld[s][p] && mStk[s][p] == t) d = p;
    for (int p = ((d == WAYS) ? WAYS - 1 : d); p >= 1; p--) begin
      mStk[s][p] = mStk[s][p-1];
      mVld[s][p] = mVld[s][p-1];
    end
    mStk[s][0] = t;
    mVld[s][0] = 1;
    if (mCnt[s][d] < CMAX) mCnt[s][d]++;
  endfunction

  function automatic int expVec(input int i);
    int v = 0;
    for (int s = 0; s < SETS; s++) begin
      v += mCnt[s][WAYS];
      for (int p = WAYS - i; p < WAYS; p++) v += mCnt[s][p];
    end
    return v;
  endfunction

  task automatic doAccess(input int s, input int t);
    @(negedge clk);
    accValid = 1'b1;
    accAddr  = {TAG_W'(t), SET_W'(s)};
    @(negedge clk);
    accValid = 1'b0;
    modelAccess(s, t);
  endtask

  task automatic readCell(input bit v, input int s, input int c, output int val);
    @(negedge clk);
    rdEn = 1'b1; rdVec = v; rdSet = SET_W'(s); rdCol = COL_W'(c);
    @(negedge clk);
    rdEn = 1'b0;
    check("R7 rdValid", int'(rdValid), 1);
    val = int'(rdData);
  endtask

  task automatic compareAll(input string tagStr);
    int val;
    for (int s = 0; s < SETS; s++)
      for (int c = 0; c <= WAYS; c++) begin
        readCell(1'b0, s, c, val);
        if (c < WAYS) check($sformatf("%s R2 R4 R10 set%0d pos%0d", tagStr, s, c), val, mCnt[s][c]);
        else          check($sformatf("%s R3 R4 R10 set%0d miss", tagStr, s), val, mCnt[s][c]);
      end
    for (int i = 0; i <= WAYS; i++) begin
      readCell(1'b1, 0, i, val);
      check($sformatf("%s R6 entry%0d", tagStr, i), val, expVec(i));
    end
  endtask

  initial begin
    int val;
    int old;
    logic [15:0] lfsr = 16'hACE1;
    modelClear();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    compareAll("R1 reset");

    // R2 R3 R4: directed depths in set 0
    doAccess(0, 1); doAccess(0, 2); doAccess(0, 1); doAccess(0, 1);
    // R4: eviction in set 1 (five distinct tags, then the first again)
    for (int t = 0; t < 5; t++) doAccess(1, t + 3);
    doAccess(1, 3);
    doAccess(1, 5);
    compareAll("directed");
    readCell(1'b1, 0, WAYS, val);
    check("R6 entry WAYS equals lookups", val, 11);
    readCell(1'b1, 0, 0, val);
    check("R6 entry 0 equals misses", val, 8);

    // R7: columns beyond WAYS read zero
    for (int c = WAYS + 1; c < (1 << COL_W); c++) begin
      readCell(1'b0, 1, c, val); check("R7 unused matrix col", val, 0);
      readCell(1'b1, 0, c, val); check("R7 unused vector col", val, 0);
    end

    // pseudo-random sweep over small tag range, all depths
    for (int n = 0; n < 240; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      doAccess(int'(lfsr[5:4]), int'(lfsr[3:0]) % 6);
    end
    compareAll("sweep");

    // R8: read in same cycle as a miss to that set
    old = mCnt[3][WAYS];
    @(negedge clk);
    rdEn = 1'b1; rdVec = 1'b0; rdSet = 2'd3; rdCol = COL_W'(WAYS);
    accValid = 1'b1; accAddr = {TAG_W'(9), SET_W'(3)};
    @(negedge clk);
    rdEn = 1'b0; accValid = 1'b0;
    check("R8 same-cycle read sees old value", int'(rdData), old);
    modelAccess(3, 9);
    readCell(1'b0, 3, WAYS, val);
    check("R8 following read sees update", val, mCnt[3][WAYS]);

    // R9: clear together with a lookup
    @(negedge clk);
    clear = 1'b1; accValid = 1'b1; accAddr = {TAG_W'(9), SET_W'(3)};
    @(negedge clk);
    clear = 1'b0; accValid = 1'b0;
    modelClear();
    compareAll("R9 R1 after clear");
    // R1: tag 9 was resident in set 3 before clear; must now miss
    doAccess(3, 9);
    readCell(1'b0, 3, WAYS, val);
    check("R1 list emptied by clear", val, 1);
    readCell(1'b0, 3, 0, val);
    check("R1 no stale hit", val, 0);

    // R5: saturation at 2^CNT_W-1
    for (int n = 0; n < CMAX + 10; n++) doAccess(2, 7);
    readCell(1'b0, 2, 0, val);
    check("R5 saturated hit counter", val, CMAX);
    compareAll("R5 R6 saturated");

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule